// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. It takes two operands, a five-bit condition mask and a width select. One compare stage works out the signed and unsigned ordering of the operands and whether they are equal, all at the same time. The mask then picks which of these relations count, and the trap fires if any picked relation holds. When it fires, the block returns a trap flag and the program-exception cause code for a trap. Instruction decode and exception vectoring happen outside the block.

Operands enter on a valid/ready stream and results leave on another. The result register holds one item. The input is accepted in any cycle where `in_ready` is high. `in_ready` is high when the result register is empty or when its current item is being taken in that same cycle. A result stays on the outputs without change until the consumer raises `out_ready`. The handshake for a result happens on a rising clock edge where both `out_valid` and `out_ready` are high, and the handshake for an input happens on a rising edge where both `in_valid` and `in_ready` are high.

Top module: `trap_cmp_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) makes the trap fire when operand A is less than operand B, both read as two's-complement numbers.
- R2: Mask bit 3 (value 0x08) makes the trap fire when A is greater than B, both read as signed numbers.
- R3: Mask bit 2 (value 0x04) makes the trap fire when A equals B. An equal pair never satisfies any of the four ordering relations.
- R4: Mask bit 1 (value 0x02) makes the trap fire when A is less than B, both read as unsigned numbers.
- R5: Mask bit 0 (value 0x01) makes the trap fire when A is greater than B, both read as unsigned numbers.
- R6: The trap flag is the OR of all relations that are both enabled and true. When the flag is 1, `out_cause` carries the trap cause code 2. When the flag is 0, `out_cause` is 0.
- R7: When `in_wide` is 0, only bits 31:0 of each operand take part in every relation, and bits 63:32 have no effect. When `in_wide` is 1, all 64 bits take part.
- R8: A mask of 0 never fires the trap. A mask of 0x1F always fires it.
- R9: An accepted input gives its result on the outputs, with `out_valid` high, right after the next rising edge.
- R10: While `out_valid` is high and `out_ready` is low, the result and `out_valid` stay unchanged and `in_ready` is low.
- R11: While reset is asserted, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can accept an input item |
| in_op_a | input | 64 | Operand A |
| in_op_b | input | 64 | Operand B |
| in_mask | input | 5 | Condition mask (bit 4 to bit 0: signed lt, signed gt, eq, unsigned lt, unsigned gt) |
| in_wide | input | 1 | 1 = compare all 64 bits, 0 = compare bits 31:0 only |
| out_valid | output | 1 | Result present (done) |
| out_ready | input | 1 | Consumer takes the result |
| out_trap | output | 1 | Trap fires |
| out_cause | output | 4 | Program-exception cause: 2 for a trap, else 0 |

## Verification
Each mask bit is tried alone on operand pairs where signed and unsigned order disagree, for example a negative value against a small positive one. A trap under one bit and no trap under its twin then shows that the signed and unsigned paths are kept apart. Equal pairs, and pairs that differ only in their upper words, are run in both widths. These separate word mode from doubleword mode and show that the upper words are ignored in word mode. The zero mask and the full mask are tried as well. Random operands and masks are run under random back-pressure, which checks both the order of results and that results hold steady while stalled.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

  localparam int unsigned NUM_REL = 5;

  // Field order matches the condition mask: slt is bit 4, ugt is bit 0.
  typedef struct packed {
    logic slt;
    logic sgt;
    logic eq;
    logic ult;
    logic ugt;
  } rel_t;

endpackage

// File: rtl/trap_rel_compare.sv
module trap_rel_compare
  import trap_cmp_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            wide,
  output rel_t            rel
);

  localparam int unsigned EXT_W = XLEN - WORD_W;

  logic [XLEN-1:0] a_sx, b_sx, a_zx, b_zx;

  generate
    if (EXT_W == 0) begin : g_same_width
      assign a_sx = op_a;
      assign b_sx = op_b;
      assign a_zx = op_a;
      assign b_zx = op_b;
    end else begin : g_width_sel
      assign a_sx = wide ? op_a : {{EXT_W{op_a[WORD_W-1]}}, op_a[WORD_W-1:0]};
      assign b_sx = wide ? op_b : {{EXT_W{op_b[WORD_W-1]}}, op_b[WORD_W-1:0]};
      assign a_zx = wide ? op_a : {{EXT_W{1'b0}}, op_a[WORD_W-1:0]};
      assign b_zx = wide ? op_b : {{EXT_W{1'b0}}, op_b[WORD_W-1:0]};
    end
  endgenerate

  always_comb begin
    rel.slt = $signed(a_sx) < $signed(b_sx);
    rel.sgt = $signed(a_sx) > $signed(b_sx);
    rel.eq  = a_zx == b_zx;
    rel.ult = a_zx < b_zx;
    rel.ugt = a_zx > b_zx;
  end

  // R3
  eq_excludes_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel.eq |-> !(rel.slt || rel.sgt || rel.ult || rel.ugt));

  // R7
  word_low_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && op_a[WORD_W-1:0] == op_b[WORD_W-1:0]) |-> rel.eq);

endmodule

// File: rtl/trap_mask_reduce.sv
module trap_mask_reduce
  import trap_cmp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  rel_t               rel,
  input  logic [NUM_REL-1:0] mask,
  output logic               hit
);

  logic [NUM_REL-1:0] rel_vec;
  logic [NUM_REL-1:0] gated;

  assign rel_vec = rel;

  generate
    for (genvar i = 0; i < NUM_REL; i++) begin : g_gate
      assign gated[i] = rel_vec[i] & mask[i];
    end
  endgenerate

  assign hit = |gated;

  // R8
  zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !hit);

  // R8
  full_mask_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> hit);

endmodule

// File: rtl/trap_out_stage.sv
module trap_out_stage #(
  parameter int unsigned         CAUSE_W = 4,
  parameter logic [CAUSE_W-1:0]  CAUSE   = 4'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               hit,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_trap,
  output logic [CAUSE_W-1:0] out_cause
);

  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_trap  <= 1'b0;
      out_cause <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_trap  <= hit;
      out_cause <= hit ? CAUSE : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  accept_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R10
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_trap) && $stable(out_cause)));

  // R6
  cause_tracks_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_trap ? (out_cause == CAUSE) : (out_cause == '0)));

endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
  import trap_cmp_pkg::*;
#(
  parameter int unsigned        XLEN       = 64,
  parameter int unsigned        WORD_W     = 32,
  parameter int unsigned        CAUSE_W    = 4,
  parameter logic [CAUSE_W-1:0] TRAP_CAUSE = 4'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [XLEN-1:0]    in_op_a,
  input  logic [XLEN-1:0]    in_op_b,
  input  logic [NUM_REL-1:0] in_mask,
  input  logic               in_wide,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_trap,
  output logic [CAUSE_W-1:0] out_cause
);

  rel_t rel;
  logic hit;

  trap_rel_compare #(.XLEN(XLEN), .WORD_W(WORD_W)) u_rel (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (in_op_a),
    .op_b  (in_op_b),
    .wide  (in_wide),
    .rel   (rel)
  );

  trap_mask_reduce u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .rel   (rel),
    .mask  (in_mask),
    .hit   (hit)
  );

  trap_out_stage #(.CAUSE_W(CAUSE_W), .CAUSE(TRAP_CAUSE)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .hit       (hit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_trap  (out_trap),
    .out_cause (out_cause)
  );

  // R10
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/test_trap_cmp_unit.sv
`timescale 1ns/1ps
module test_trap_cmp_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_op_a = '0;
  logic [63:0] in_op_b = '0;
  logic [4:0]  in_mask = '0;
  logic        in_wide = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_trap;
  logic [3:0]  out_cause;

  int n_tests = 0;
  int n_fail  = 0;
  int rdy_mode = 0;
  bit finished = 1'b0;

  typedef struct { bit trap; string tag; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  trap_cmp_unit i_trap_cmp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op_a(in_op_a), .in_op_b(in_op_b), .in_mask(in_mask), .in_wide(in_wide),
    .out_valid(out_valid), .out_ready(out_ready), .out_trap(out_trap),
    .out_cause(out_cause)
  );

  function automatic bit model(logic [63:0] a, logic [63:0] b, logic [4:0] m, bit w);
    longint          sa, sb_;
    longint unsigned ua, ub;
    if (w) begin
      sa = longint'(a); sb_ = longint'(b); ua = a; ub = b;
    end else begin
      sa = longint'(int'(a[31:0])); sb_ = longint'(int'(b[31:0]));
      ua = {32'd0, a[31:0]};        ub = {32'd0, b[31:0]};
    end
    return (m[4] && sa < sb_) || (m[3] && sa > sb_) || (m[2] && ua == ub) ||
           (m[1] && ua < ub)  || (m[0] && ua > ub);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // monitor: a handshake seen here completes at the next rising edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(out_trap == e.trap, {e.tag, " trap"}, out_trap, e.trap);
          chk(out_cause == (e.trap ? 4'd2 : 4'd0), "R6 cause", out_cause, e.trap ? 2 : 0);
        end
      end
    end
  end

  task automatic send(logic [63:0] a, logic [63:0] b, logic [4:0] m, bit w, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_op_a = a; in_op_b = b; in_mask = m; in_wide = w;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    e.trap = model(a, b, m, w);
    e.tag  = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] neg1, pos1, hi_a;
    neg1 = 64'hFFFF_FFFF_FFFF_FFFF;
    pos1 = 64'd1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1,  "R11 in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R4: -1 vs 1 -> signed lt, unsigned gt
    send(neg1, pos1, 5'h10, 1, "R1 slt fires");
    send(neg1, pos1, 5'h02, 1, "R4 ult quiet on neg");
    send(pos1, neg1, 5'h02, 1, "R4 ult fires");
    send(pos1, neg1, 5'h10, 1, "R1 slt quiet");
    // R2 / R5
    send(pos1, neg1, 5'h08, 1, "R2 sgt fires");
    send(neg1, pos1, 5'h08, 1, "R2 sgt quiet");
    send(neg1, pos1, 5'h01, 1, "R5 ugt fires");
    send(pos1, neg1, 5'h01, 1, "R5 ugt quiet");
    // R3
    send(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, 1, "R3 eq fires");
    send(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h1B, 1, "R3 eq no order");
    send(64'd5, 64'd6, 5'h04, 1, "R3 eq quiet");
    // R7 word mode ignores upper words
    hi_a = 64'hFFFF_FFFF_0000_0005;
    send(hi_a, 64'd5, 5'h04, 0, "R7 word eq fires");
    send(hi_a, 64'd5, 5'h04, 1, "R7 wide eq quiet");
    send(64'h0000_0000_8000_0000, pos1, 5'h10, 0, "R7 word signed lt");
    send(64'h0000_0000_8000_0000, pos1, 5'h10, 1, "R7 wide signed lt quiet");
    send(64'h0000_0000_8000_0000, pos1, 5'h01, 0, "R7 word unsigned gt");
    // R8 and R6
    send(neg1, pos1, 5'h00, 1, "R8 zero mask");
    send(hi_a, hi_a, 5'h00, 0, "R8 zero mask eq");
    send(hi_a, 64'd7, 5'h1F, 1, "R8 full mask");
    send(hi_a, hi_a, 5'h1F, 0, "R8 full mask eq");
    send(neg1, pos1, 5'h12, 1, "R6 or of two");
    drain();

    // R9 latency
    chk(out_valid == 1'b0, "R9 idle before", out_valid, 0);
    begin
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; in_op_a = 64'd3; in_op_b = 64'd3; in_mask = 5'h04; in_wide = 1;
      @(posedge clk); #1;
      in_valid = 1'b0;
      e.trap = 1'b1; e.tag = "R9 latency";
      sb.push_back(e);
      chk(out_valid == 1'b1, "R9 valid one cycle later", out_valid, 1);
    end
    drain();

    // R10 stall
    rdy_mode = 2;
    @(negedge clk);
    send(pos1, neg1, 5'h08, 1, "R10 stalled result");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(out_valid == 1'b1 && out_trap == 1'b1, "R10 held", {out_valid, out_trap}, 3);
      chk(in_ready == 1'b0, "R10 in_ready low", in_ready, 0);
    end
    rdy_mode = 0;
    drain();

    // random under back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      case ($urandom % 4)
        0: b = a;
        1: b = {$urandom, a[31:0]};
        2: b = a ^ (64'd1 << ($urandom % 64));
        default: b = {$urandom, $urandom};
      endcase
      send(a, b, 5'($urandom), 1'($urandom), "R6 random");
    end
    rdy_mode = 0;
    drain();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule